// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block keeps the single reservation that one processor holds between a load-locked access and the store-conditional that ends it. It lets software do an atomic read-modify-write of an aligned 4-byte or 8-byte shared word. A load-locked request records the aligned 16-byte block that holds the target address. Several things cancel that reservation: writes by other agents seen on the snoop port, ordinary stores from this processor into the same block, and exception, interrupt or taken-branch pulses.

A store-conditional arrives on a valid/ready request stream. Each accepted request produces exactly one beat on a valid/ready response stream one cycle later. That beat carries the success flag and the write command (address, size, data). The memory side performs the write only for a beat with `rsp_ok` set. The response is a single register, so back-pressure works like this: while a response is held (`rsp_valid` high, `rsp_ready` low), `sc_ready` is low and no new store-conditional is taken. Ordinary stores are not gated here; the block only watches them.

Top module: `resv_monitor`

## Requirements
- R1: An accepted store-conditional succeeds (`rsp_ok`=1) only when a reservation exists, the store-conditional address lies in the reserved 16-byte block (address bits [3:0] ignored), the access is aligned, and no cancelling condition occurs in the same cycle. The response carries the request's address, size and data.
- R2: A store-conditional accepted when no reservation exists returns `rsp_ok`=0.
- R3: A snoop write whose address lies in the reserved block cancels the reservation. A snoop write to any other block leaves it intact.
- R4: An exception pulse or an interrupt pulse cancels the reservation.
- R5: A taken-branch pulse cancels the reservation.
- R6: A local ordinary store into the reserved block cancels the reservation. A local store to another block does not.
- R7: The size encoding is 0 = 4 bytes, which needs address bits [1:0]=0, and 1 = 8 bytes, which needs address bits [2:0]=0. A misaligned store-conditional fails. A misaligned load-locked leaves no reservation.
- R8: Every accepted store-conditional clears the reservation, whether it succeeds or fails.
- R9: A load-locked replaces any earlier reservation with its own block.
- R10: A store-conditional to a block other than the reserved one fails.
- R11: A snoop write to the reserved block in the same cycle that a store-conditional is accepted makes that store-conditional fail.
- R12: The response is valid in the cycle after acceptance. It stays valid with stable fields while `rsp_ready` is low. `sc_ready` is high exactly when no response is held or the held one is being taken.
- R13: After reset there is no reservation, `rsp_valid` is 0 and `sc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ll_req | input | 1 | Load-locked pulse |
| ll_addr | input | ADDR_W | Load-locked address |
| ll_size | input | 1 | Load-locked size (0 = 4 B, 1 = 8 B) |
| sc_valid | input | 1 | Store-conditional request valid |
| sc_ready | output | 1 | Store-conditional request accepted |
| sc_addr | input | ADDR_W | Store-conditional address |
| sc_size | input | 1 | Store-conditional size |
| sc_data | input | DATA_W | Store-conditional data |
| st_wr | input | 1 | Local ordinary store pulse |
| st_addr | input | ADDR_W | Local ordinary store address |
| snoop_wr | input | 1 | Write by another agent |
| snoop_addr | input | ADDR_W | Address of that write |
| exc_evt | input | 1 | Exception taken |
| irq_evt | input | 1 | Interrupt taken |
| br_taken | input | 1 | Taken branch |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted by memory side |
| rsp_ok | output | 1 | Success flag; write is performed only when 1 |
| rsp_addr | output | ADDR_W | Write address |
| rsp_size | output | 1 | Write size |
| rsp_data | output | DATA_W | Write data |

## Verification
The bench probes the edges of the 16-byte block. A design that compared the exact address would fail a store-conditional after a load-locked to a neighbouring word, and would let a snoop at offset 8 pass unnoticed. It repeats a store-conditional right after a successful one; a design that kept the reservation would report a second success. It also drives a snoop to the same block in the very cycle of the store-conditional, where a design that gave the store priority would succeed wrongly. It checks misaligned 8-byte accesses and a held response under back-pressure, where a design that dropped or overwrote the beat would lose a result.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic {
    SZ_WORD4 = 1'b0,
    SZ_WORD8 = 1'b1
  } acc_size_e;

  localparam int unsigned BLOCK_LG_DEFAULT = 4;
endpackage

// File: rtl/resv_align_chk.sv
module resv_align_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              size,
  output logic              aligned
);
  import resv_pkg::*;

  always_comb begin
    if (acc_size_e'(size) == SZ_WORD8) aligned = (addr[2:0] == 3'b000);
    else                               aligned = (addr[1:0] == 2'b00);
  end

  logic unused_hi;
  assign unused_hi = ^addr[ADDR_W-1:3];
endmodule

// File: rtl/resv_blk_hit.sv
module resv_blk_hit #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BLK_LG = 4,
  localparam int unsigned TAG_W = ADDR_W - BLK_LG
) (
  input  logic [TAG_W-1:0]  tag,
  input  logic              tag_vld,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = tag_vld && (addr[ADDR_W-1:BLK_LG] == tag);

  logic unused_lo;
  assign unused_lo = ^addr[BLK_LG-1:0];
endmodule

// File: rtl/resv_state.sv
module resv_state #(
  parameter int unsigned TAG_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr,
  output logic             vld,
  output logic [TAG_W-1:0] tag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      tag <= '0;
    end else if (set) begin
      vld <= 1'b1;
      tag <= set_tag;
    end else if (clr) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned BLK_LG = resv_pkg::BLOCK_LG_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_req,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              ll_size,
  input  logic              sc_valid,
  output logic              sc_ready,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              sc_size,
  input  logic [DATA_W-1:0] sc_data,
  input  logic              st_wr,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              snoop_wr,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              exc_evt,
  input  logic              irq_evt,
  input  logic              br_taken,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ok,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_size,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int unsigned TAG_W   = ADDR_W - BLK_LG;
  localparam int unsigned N_PROBE = 3;  // 0 snoop, 1 local store, 2 store-conditional
  localparam int unsigned N_NEW   = 2;  // writers checked against a new load-locked block

  logic             resv_vld;
  logic [TAG_W-1:0] resv_tag;
  logic [TAG_W-1:0] ll_tag;

  logic [ADDR_W-1:0] probe_addr [N_PROBE];
  logic [N_PROBE-1:0] cur_hit;
  logic [N_NEW-1:0]   new_hit;
  logic [1:0]         align_ok;   // 0 load-locked, 1 store-conditional
  logic [ADDR_W-1:0]  align_addr [2];
  logic [1:0]         align_size;

  assign probe_addr[0] = snoop_addr;
  assign probe_addr[1] = st_addr;
  assign probe_addr[2] = sc_addr;
  assign ll_tag        = ll_addr[ADDR_W-1:BLK_LG];

  genvar gi;
  generate
    for (gi = 0; gi < N_PROBE; gi++) begin : g_cur
      resv_blk_hit #(.ADDR_W(ADDR_W), .BLK_LG(BLK_LG)) u_hit (
        .tag(resv_tag), .tag_vld(resv_vld), .addr(probe_addr[gi]), .hit(cur_hit[gi])
      );
    end
    for (gi = 0; gi < N_NEW; gi++) begin : g_new
      resv_blk_hit #(.ADDR_W(ADDR_W), .BLK_LG(BLK_LG)) u_hit (
        .tag(ll_tag), .tag_vld(1'b1), .addr(probe_addr[gi]), .hit(new_hit[gi])
      );
    end
  endgenerate

  assign align_addr[0] = ll_addr;
  assign align_addr[1] = sc_addr;
  assign align_size    = {sc_size, ll_size};

  generate
    for (gi = 0; gi < 2; gi++) begin : g_align
      resv_align_chk #(.ADDR_W(ADDR_W)) u_align (
        .addr(align_addr[gi]), .size(align_size[gi]), .aligned(align_ok[gi])
      );
    end
  endgenerate

  logic evt_kill, cancel_cur, sc_fire, sc_pass, ll_ok, st_clr;

  always_comb begin
    evt_kill   = exc_evt | irq_evt | br_taken;
    cancel_cur = evt_kill | (snoop_wr & cur_hit[0]) | (st_wr & cur_hit[1]);
    sc_ready   = !rsp_valid || rsp_ready;
    sc_fire    = sc_valid && sc_ready;
    sc_pass    = cur_hit[2] && align_ok[1] && !cancel_cur;
    ll_ok      = ll_req && align_ok[0] && !evt_kill &&
                 !(snoop_wr && new_hit[0]) && !(st_wr && new_hit[1]);
    st_clr     = cancel_cur || sc_fire || ll_req;
  end

  resv_state #(.TAG_W(TAG_W)) u_state (
    .clk(clk), .rst_n(rst_n), .set(ll_ok), .set_tag(ll_tag),
    .clr(st_clr), .vld(resv_vld), .tag(resv_tag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_addr  <= '0;
      rsp_size  <= 1'b0;
      rsp_data  <= '0;
    end else if (sc_fire) begin
      rsp_valid <= 1'b1;
      rsp_ok    <= sc_pass;
      rsp_addr  <= sc_addr;
      rsp_size  <= sc_size;
      rsp_data  <= sc_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned BLK_LG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sc_valid,
  input logic              sc_ready,
  input logic [ADDR_W-1:0] sc_addr,
  input logic              sc_size,
  input logic              ll_req,
  input logic              snoop_wr,
  input logic [ADDR_W-1:0] snoop_addr,
  input logic              exc_evt,
  input logic              irq_evt,
  input logic              br_taken,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_ok,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [DATA_W-1:0] rsp_data,
  input logic              resv_vld
);
  logic fire, misal, same_blk;
  assign fire     = sc_valid && sc_ready;
  assign misal    = sc_size ? (sc_addr[2:0] != 3'b000) : (sc_addr[1:0] != 2'b00);
  assign same_blk = snoop_addr[ADDR_W-1:BLK_LG] == sc_addr[ADDR_W-1:BLK_LG];

  a_r12_accept_resp: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ok) && $stable(rsp_addr) && $stable(rsp_data));
  a_r2_no_resv_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !resv_vld |=> !rsp_ok);
  a_r4_event_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (exc_evt || irq_evt) |=> !rsp_ok);
  a_r5_branch_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fire && br_taken |=> !rsp_ok);
  a_r7_misalign_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fire && misal |=> !rsp_ok);
  a_r11_snoop_race: assert property (@(posedge clk) disable iff (!rst_n)
    fire && snoop_wr && same_blk |=> !rsp_ok);
  a_r8_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ll_req |=> !resv_vld);
endmodule

bind resv_monitor resv_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_LG(BLK_LG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sc_valid(sc_valid), .sc_ready(sc_ready), .sc_addr(sc_addr),
  .sc_size(sc_size), .ll_req(ll_req), .snoop_wr(snoop_wr), .snoop_addr(snoop_addr),
  .exc_evt(exc_evt), .irq_evt(irq_evt), .br_taken(br_taken), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
  .resv_vld(resv_vld)
);

// File: tb/resv_monitor_bench.sv
`timescale 1ns/1ps
module resv_monitor_bench;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ll_req = 0, ll_size = 0, sc_valid = 0, sc_size = 0, st_wr = 0, snoop_wr = 0;
  logic exc_evt = 0, irq_evt = 0, br_taken = 0, rsp_ready = 1;
  logic [AW-1:0] ll_addr = '0, sc_addr = '0, st_addr = '0, snoop_addr = '0;
  logic [DW-1:0] sc_data = '0;
  logic sc_ready, rsp_valid, rsp_ok, rsp_size;
  logic [AW-1:0] rsp_addr;
  logic [DW-1:0] rsp_data;

  always #2 clk = ~clk;  // 250 MHz

  resv_monitor u_resv_monitor (
    .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .ll_addr(ll_addr), .ll_size(ll_size),
    .sc_valid(sc_valid), .sc_ready(sc_ready), .sc_addr(sc_addr), .sc_size(sc_size),
    .sc_data(sc_data), .st_wr(st_wr), .st_addr(st_addr), .snoop_wr(snoop_wr),
    .snoop_addr(snoop_addr), .exc_evt(exc_evt), .irq_evt(irq_evt), .br_taken(br_taken),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr),
    .rsp_size(rsp_size), .rsp_data(rsp_data)
  );

  typedef struct packed {
    logic          ok;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [7:0]    req;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic          side_snoop = 0;
  logic [AW-1:0] side_snoop_addr = '0;

  localparam logic [AW-1:0] A = 32'h1000_0040;

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_ll(input logic [AW-1:0] a, input logic sz);
    @(negedge clk); ll_req = 1; ll_addr = a; ll_size = sz;
    @(negedge clk); ll_req = 0;
  endtask

  task automatic do_snoop(input logic [AW-1:0] a);
    @(negedge clk); snoop_wr = 1; snoop_addr = a;
    @(negedge clk); snoop_wr = 0;
  endtask

  task automatic do_store(input logic [AW-1:0] a);
    @(negedge clk); st_wr = 1; st_addr = a;
    @(negedge clk); st_wr = 0;
  endtask

  task automatic do_evt(input int which);
    @(negedge clk);
    exc_evt = (which == 0); irq_evt = (which == 1); br_taken = (which == 2);
    @(negedge clk); exc_evt = 0; irq_evt = 0; br_taken = 0;
  endtask

  // driver: issues one store-conditional and pushes the expected response
  task automatic do_sc(input logic [AW-1:0] a, input logic sz, input logic [DW-1:0] d,
                       input bit ok, input logic [7:0] req);
    exp_t e;
    @(negedge clk);
    sc_valid = 1; sc_addr = a; sc_size = sz; sc_data = d;
    snoop_wr = side_snoop; snoop_addr = side_snoop_addr;
    while (!sc_ready) @(negedge clk);
    e.ok = ok; e.addr = a; e.data = d; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    sc_valid = 0; snoop_wr = 0; side_snoop = 0;
  endtask

  // monitor: pops the scoreboard on each accepted response beat
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R12 unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_ok == e.ok, $sformatf("R%0d ok flag", e.req), rsp_ok, e.ok);
          check(rsp_addr == e.addr && rsp_data == e.data,
                $sformatf("R%0d write fields", e.req), rsp_addr, e.addr);
        end
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R13 reset state
    check(rsp_valid == 0, "R13 rsp_valid after reset", rsp_valid, 0);
    check(sc_ready == 1, "R13 sc_ready after reset", sc_ready, 1);
    rst_n = 1;
    do_sc(A, 1, 64'h11, 0, 13);                  // R13 no reservation at start

    do_ll(A, 1); do_sc(A, 1, 64'hA1, 1, 1);      // R1 success
    do_sc(A, 1, 64'hA2, 0, 8);                   // R8 cleared by previous SC, R2
    do_sc(A + 8, 1, 64'hA3, 0, 2);               // R2 no reservation

    do_ll(A, 1); do_snoop(A + 8); do_sc(A, 1, 64'hB1, 0, 3);   // R3 remote in block
    do_ll(A, 1); do_snoop(A + 16); do_sc(A, 1, 64'hB2, 1, 3);  // R3 remote other block
    do_ll(A + 8, 1); do_sc(A, 0, 64'hB3, 1, 1);                // R1 block match, offset ignored

    do_ll(A, 1); do_evt(1); do_sc(A, 1, 64'hC1, 0, 4);   // R4 interrupt
    do_ll(A, 1); do_evt(0); do_sc(A, 1, 64'hC2, 0, 4);   // R4 exception
    do_ll(A, 1); do_evt(2); do_sc(A, 1, 64'hC3, 0, 5);   // R5 taken branch

    do_ll(A, 1); do_store(A + 4); do_sc(A, 1, 64'hD1, 0, 6);   // R6 local store in block
    do_ll(A, 1); do_store(A + 32); do_sc(A, 1, 64'hD2, 1, 6);  // R6 local store elsewhere

    do_ll(A, 0); do_sc(A + 2, 0, 64'hE1, 0, 7);           // R7 misaligned SC
    do_ll(A + 4, 1); do_sc(A, 1, 64'hE2, 0, 7);           // R7 misaligned LL
    do_ll(A + 4, 0); do_sc(A + 4, 0, 64'hE3, 1, 7);       // R7 aligned 4-byte
    do_ll(A, 1); do_sc(A + 4, 1, 64'hE4, 0, 7);           // R7 8-byte at offset 4

    do_ll(A, 1); do_ll(A + 64, 1); do_sc(A, 1, 64'hF1, 0, 9);       // R9 replaced
    do_ll(A, 1); do_ll(A + 64, 1); do_sc(A + 64, 1, 64'hF2, 1, 9);  // R9 new block

    do_ll(A, 1); do_sc(A + 16, 1, 64'h71, 0, 10);   // R10 other block
    do_sc(A, 1, 64'h72, 0, 8);                      // R8 failed SC also cleared

    do_ll(A, 1); side_snoop = 1; side_snoop_addr = A + 12;
    do_sc(A, 1, 64'h81, 0, 11);                     // R11 same-cycle remote wins
    do_ll(A, 1); side_snoop = 1; side_snoop_addr = A + 128;
    do_sc(A, 1, 64'h82, 1, 11);                     // R11 same-cycle remote elsewhere

    // R12 back-pressure: hold the response, then release
    @(negedge clk); rsp_ready = 0;
    do_ll(A, 1); do_sc(A, 1, 64'h91, 1, 12);
    repeat (3) @(negedge clk);
    #1;
    check(rsp_valid == 1, "R12 held valid", rsp_valid, 1);
    check(sc_ready == 0, "R12 sc_ready low while held", sc_ready, 0);
    check(rsp_addr == A && rsp_data == 64'h91, "R12 held fields", rsp_data, 64'h91);
    @(negedge clk); rsp_ready = 1;
    repeat (4) @(negedge clk);
    #1;
    check(rsp_valid == 0, "R12 drained", rsp_valid, 0);
    check(exp_q.size() == 0, "R12 all responses seen", exp_q.size(), 0);
    finish_up();
  end
endmodule